// File: doc/BRIEF.md
# Modulo Timer PWM Channel

This block is a pulse-width generator built around a free-running up-counter. A prescaler divides the bus clock by a power of two and produces the counter's advance ticks. The counter climbs from zero to a programmed limit and then restarts from zero. Each restart is an overflow event, and the time between two overflows is the PWM period. A compare channel watches the counter. When the counter reaches the compare value, the output pin is forced to a programmed level. The pin can also flip on every overflow. Together these two events give a pulse whose width runs from the overflow to the compare match.

Software programs the block through a small write-only register port. There are four registers: control, modulo limit, compare A and compare B. In buffered mode the two compare registers take turns. The one written most recently takes control at the next overflow, so a new width never splits a period. Buffered mode also frees the second pin, which then drives a level taken from the control register.

Top module: `mod_pwm_timer`

## Requirements
- R1: While rst_ni is low, and right after it is released, cnt_o is 0, pwm_o is 0 and aux_o is 0. All registers reset to 0, so the timer is stopped.
- R2: Register addresses are fixed: 0 is control, 1 is the modulo limit, 2 is compare A and 3 is compare B. On each tick the counter steps by one. On the tick where it equals the modulo limit it returns to 0, so a period lasts (limit+1) ticks.
- R3: Control bits [PS_W-1:0] hold the prescale code p, and a tick occurs once every 2^p bus clocks. Code 0 ticks on every clock. With limit 31 and code 2, a period is 128 clocks.
- R4: Control bit PS_W is toggle enable. When it is set, the pin inverts at each overflow. When it is clear, an overflow leaves the pin unchanged.
- R5: On a tick where the counter's new value equals the compare value in use, the pin takes the level in control bit PS_W+1 (0 clears, 1 sets). A match beats a coinciding overflow toggle. With limit 255, compare 128, level 0 and toggle on, the pin is high for 128 of every 256 clocks.
- R6: A compare value above the modulo limit never matches. The pin then changes only at overflows and stays steady between them.
- R7: Control bit PS_W+2 selects buffered mode. In this mode, the compare register written last before an overflow controls the period that overflow starts. The switch happens only at overflow.
- R8: Writing the compare register that is in use changes the match point at once, within the current period.
- R9: With buffered mode off, compare A alone sets the width, and writes to compare B have no effect on pwm_o.
- R10: aux_o drives control bit PS_W+4 while buffered mode is on, and is 0 while it is off.
- R11: Control bit PS_W+3 is run. While it is clear, the prescaler, the counter and the pin all hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | CNT_W | Write data |
| cnt_o | output | CNT_W | Current counter value |
| pwm_o | output | 1 | PWM channel pin |
| aux_o | output | 1 | General-purpose pin freed by buffered mode |

## Verification
The bench builds the block with CNT_W=10 and PS_W=3. The narrow counter lets it reach a full roll-over past a modulo limit that was lowered below the count, within about a thousand clocks. The 3-bit prescale field lets it reach the divide-by-4 case and the control bits at positions 3 to 7. Modulo limits of 255, 31 and 15 let duty windows covering several whole periods show exact high-time counts. These cover 50% duty, a compare value out of range, a compare at zero against a toggle, and the alternating compare registers.

// File: rtl/mpt_pkg.sv
package mpt_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_MOD   = 2'd1,
    ADDR_CMP_A = 2'd2,
    ADDR_CMP_B = 2'd3
  } reg_addr_e;

  localparam int unsigned NUM_CMP = 2;
  // control field offsets above the prescale code
  localparam int unsigned CTRL_TOG = 0;
  localparam int unsigned CTRL_LVL = 1;
  localparam int unsigned CTRL_BUF = 2;
  localparam int unsigned CTRL_RUN = 3;
  localparam int unsigned CTRL_AUX = 4;
  localparam int unsigned CTRL_EXTRA = 5;
endpackage

// File: rtl/mpt_prescaler.sv
module mpt_prescaler #(
  parameter int unsigned PS_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [PS_W-1:0] sel_i,
  output logic            tick_o
);
  localparam int unsigned DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  // bit b of the divider takes part when the code exceeds b
  for (genvar b = 0; b < DIV_W; b++) begin : g_mask
    assign mask[b] = (32'(sel_i) > b);
  end

  assign tick_o = run_i & ((div_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    div_q <= '0;
    else if (run_i) div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/mpt_counter.sv
module mpt_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] mod_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] nxt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_lim;

  assign at_lim = (cnt_q == mod_i);
  assign wrap_o = tick_i & at_lim;
  assign nxt_o  = at_lim ? '0 : cnt_q + 1'b1;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= nxt_o;
  end
endmodule

// File: rtl/mpt_channel.sv
module mpt_channel #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] nxt_i,
  input  logic [CNT_W-1:0] cmp_a_i,
  input  logic [CNT_W-1:0] cmp_b_i,
  input  logic             buf_en_i,
  input  logic             last_wr_i,
  input  logic             tog_en_i,
  input  logic             lvl_i,
  output logic             pin_o,
  output logic             act_sel_o,
  output logic             match_o
);
  logic             act_sel_q;
  logic             sel_eff;
  logic [CNT_W-1:0] cmp_val;
  logic             pin_q;

  // the period that starts at this wrap already uses the new selection
  always_comb begin
    sel_eff = 1'b0;
    if (buf_en_i) sel_eff = wrap_i ? last_wr_i : act_sel_q;
    cmp_val = sel_eff ? cmp_b_i : cmp_a_i;
  end

  assign match_o = tick_i & (nxt_i == cmp_val);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q     <= 1'b0;
      act_sel_q <= 1'b0;
    end else begin
      if (match_o)                pin_q <= lvl_i;
      else if (wrap_i && tog_en_i) pin_q <= ~pin_q;
      if (wrap_i) act_sel_q <= last_wr_i;
    end
  end

  assign pin_o     = pin_q;
  assign act_sel_o = act_sel_q;
endmodule

// File: rtl/mod_pwm_timer.sv
module mod_pwm_timer
  import mpt_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PS_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pwm_o,
  output logic             aux_o
);
  localparam int unsigned CTRL_W = PS_W + CTRL_EXTRA;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  mod_q;
  logic [CNT_W-1:0]  cmp_q [NUM_CMP];
  logic              last_wr_q;

  logic [PS_W-1:0]   ps_sel;
  logic              tog_en, cmp_lvl, buf_en, run_en, aux_val;
  logic              tick, wrap, match, act_sel;
  logic [CNT_W-1:0]  nxt;

  assign ps_sel  = ctrl_q[PS_W-1:0];
  assign tog_en  = ctrl_q[PS_W+CTRL_TOG];
  assign cmp_lvl = ctrl_q[PS_W+CTRL_LVL];
  assign buf_en  = ctrl_q[PS_W+CTRL_BUF];
  assign run_en  = ctrl_q[PS_W+CTRL_RUN];
  assign aux_val = ctrl_q[PS_W+CTRL_AUX];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mod_q  <= '0;
    end else if (wr_en_i) begin
      if (reg_addr_e'(wr_addr_i) == ADDR_CTRL) ctrl_q <= wr_data_i[CTRL_W-1:0];
      if (reg_addr_e'(wr_addr_i) == ADDR_MOD)  mod_q  <= wr_data_i;
    end
  end

  for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
    localparam logic [1:0] ADDR = 2'(ADDR_CMP_A) + 2'(c);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          cmp_q[c] <= '0;
      else if (wr_en_i && wr_addr_i == ADDR) cmp_q[c] <= wr_data_i;
    end
  end

  // remembers which compare register was written most recently
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_wr_q <= 1'b0;
    else if (wr_en_i && reg_addr_e'(wr_addr_i) == ADDR_CMP_A) last_wr_q <= 1'b0;
    else if (wr_en_i && reg_addr_e'(wr_addr_i) == ADDR_CMP_B) last_wr_q <= 1'b1;
  end

  mpt_prescaler #(.PS_W(PS_W)) u_ps (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run_en),
    .sel_i (ps_sel),
    .tick_o(tick)
  );

  mpt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .mod_i (mod_q),
    .cnt_o (cnt_o),
    .nxt_o (nxt),
    .wrap_o(wrap)
  );

  mpt_channel #(.CNT_W(CNT_W)) u_ch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .wrap_i   (wrap),
    .nxt_i    (nxt),
    .cmp_a_i  (cmp_q[0]),
    .cmp_b_i  (cmp_q[1]),
    .buf_en_i (buf_en),
    .last_wr_i(last_wr_q),
    .tog_en_i (tog_en),
    .lvl_i    (cmp_lvl),
    .pin_o    (pwm_o),
    .act_sel_o(act_sel),
    .match_o  (match)
  );

  assign aux_o = buf_en & aux_val;
endmodule

// File: rtl/mpt_checks.sv
module mpt_checks #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cnt_o,
  input logic             pwm_o,
  input logic             aux_o,
  input logic             tick,
  input logic             wrap,
  input logic             match,
  input logic             act_sel,
  input logic             tog_en,
  input logic             cmp_lvl,
  input logic             buf_en,
  input logic             run_en
);
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !wrap) |=> cnt_o == $past(cnt_o) + 1'b1);

  p_wrap_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> cnt_o == '0);

  p_toggle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && tog_en && !match) |=> pwm_o != $past(pwm_o));

  p_match_level_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match |=> pwm_o == $past(cmp_lvl));

  p_quiet_pin_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(pwm_o));

  p_sel_at_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> $stable(act_sel));

  p_aux_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aux_o |-> buf_en);

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_en |=> ($stable(cnt_o) && $stable(pwm_o)));
endmodule

bind mod_pwm_timer mpt_checks #(.CNT_W(CNT_W)) u_mpt_checks (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cnt_o  (cnt_o),
  .pwm_o  (pwm_o),
  .aux_o  (aux_o),
  .tick   (tick),
  .wrap   (wrap),
  .match  (match),
  .act_sel(act_sel),
  .tog_en (tog_en),
  .cmp_lvl(cmp_lvl),
  .buf_en (buf_en),
  .run_en (run_en)
);

// File: tb/test_mod_pwm_timer.sv
module test_mod_pwm_timer;
  localparam int CLK_T = 10;
  localparam int CNT_W = 10;
  localparam int PS_W  = 3;
  localparam int CNT_MOD = 1 << CNT_W;
  localparam int DIV_MOD = 1 << ((1 << PS_W) - 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic [CNT_W-1:0] cnt;
  logic             pwm, aux;

  int total = 0;
  int bad = 0;
  bit live = 1'b0;
  string cur_req = "R1";

  // reference model state
  int m_div, m_cnt, m_pin, m_act, m_last;
  int r_ctrl, r_mod, r_a, r_b;

  always #(CLK_T/2) clk = ~clk;

  mod_pwm_timer #(.CNT_W(CNT_W), .PS_W(PS_W)) i_mod_pwm_timer (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .cnt_o(cnt), .pwm_o(pwm), .aux_o(aux)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 0; m_cnt = 0; m_pin = 0; m_act = 0; m_last = 0;
      r_ctrl = 0; r_mod = 0; r_a = 0; r_b = 0;
    end else begin
      int ps, run, tog, lvl, bufm, tick, wrap, nxt, sel, cv;
      ps = r_ctrl % 8; tog = (r_ctrl >> 3) & 1; lvl = (r_ctrl >> 4) & 1;
      bufm = (r_ctrl >> 5) & 1; run = (r_ctrl >> 6) & 1;
      tick = (run != 0) && ((m_div % (1 << ps)) == (1 << ps) - 1);
      if (run != 0) m_div = (m_div + 1) % DIV_MOD;
      if (tick != 0) begin
        wrap = (m_cnt == r_mod);
        nxt = wrap ? 0 : (m_cnt + 1) % CNT_MOD;
        sel = (bufm != 0) ? (wrap ? m_last : m_act) : 0;
        cv = (sel != 0) ? r_b : r_a;
        if (nxt == cv) m_pin = lvl;
        else if (wrap && tog != 0) m_pin = 1 - m_pin;
        if (wrap) m_act = m_last;
        m_cnt = nxt;
      end
      if (wr_en) begin
        case (wr_addr)
          2'd0: r_ctrl = int'(wr_data) % 256;
          2'd1: r_mod = int'(wr_data);
          2'd2: begin r_a = int'(wr_data); m_last = 0; end
          default: begin r_b = int'(wr_data); m_last = 1; end
        endcase
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (live) begin
      check(cur_req, "cnt_o", int'(cnt), m_cnt);
      check(cur_req, "pwm_o", int'(pwm), m_pin);
      check("R10", "aux_o", int'(aux), ((r_ctrl >> 5) & 1) & ((r_ctrl >> 7) & 1));
    end
  end

  function automatic logic [CNT_W-1:0] ctrl(int ps, int tog, int lvl, int bufm, int run, int ax);
    return CNT_W'(ps | (tog << 3) | (lvl << 4) | (bufm << 5) | (run << 6) | (ax << 7));
  endfunction

  task automatic wr(input logic [1:0] a, input logic [CNT_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic duty(input string req, input int n, input int exp);
    int hi = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm) hi++;
    end
    check(req, "high cycles", hi, exp);
  endtask

  initial begin
    #(CLK_T * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int held;
    idle(3);
    check("R1", "cnt_o in reset", int'(cnt), 0);
    check("R1", "pwm_o in reset", int'(pwm), 0);
    check("R1", "aux_o in reset", int'(aux), 0);
    rst_n = 1'b1;
    idle(2);
    live = 1'b1;
    check("R1", "cnt_o after reset", int'(cnt), 0);

    // R2 R5: 50% duty at limit 255, compare 128
    cur_req = "R2 R5";
    wr(2'd1, 10'd255);
    wr(2'd2, 10'd128);
    wr(2'd0, ctrl(0, 1, 0, 0, 1, 0));
    idle(600);
    duty("R5", 1024, 512);

    // limit 15; counter may roll over full range first
    cur_req = "R6";
    wr(2'd2, 10'd200);
    wr(2'd1, 10'd15);
    idle(1100);
    duty("R6", 64, 32);

    cur_req = "R4";
    wr(2'd2, 10'd4);
    wr(2'd0, ctrl(0, 0, 1, 0, 1, 0));
    idle(40);
    duty("R4", 64, 64);

    cur_req = "R5";
    wr(2'd2, 10'd0);
    wr(2'd0, ctrl(0, 1, 0, 0, 1, 0));
    idle(40);
    duty("R5", 64, 0);

    // buffered mode at limit 31
    cur_req = "R7";
    wr(2'd1, 10'd31);
    wr(2'd2, 10'd8);
    wr(2'd3, 10'd20);
    wr(2'd0, ctrl(0, 1, 0, 1, 1, 1));
    idle(100);
    duty("R7", 128, 80);
    check("R10", "aux_o buffered", int'(aux), 1);
    wr(2'd2, 10'd12);
    idle(64);
    duty("R7", 128, 48);

    cur_req = "R8";
    wr(2'd2, 10'd5);
    idle(64);
    duty("R8", 128, 20);

    cur_req = "R9";
    wr(2'd0, ctrl(0, 1, 0, 0, 1, 1));
    wr(2'd3, 10'd25);
    idle(64);
    duty("R9", 128, 20);
    check("R10", "aux_o unbuffered", int'(aux), 0);

    cur_req = "R3";
    wr(2'd2, 10'd4);
    wr(2'd0, ctrl(2, 1, 0, 0, 1, 0));
    idle(300);
    duty("R3", 512, 64);

    cur_req = "R11";
    wr(2'd0, ctrl(2, 1, 0, 0, 0, 0));
    held = int'(cnt);
    idle(20);
    check("R11", "cnt_o held", int'(cnt), held);

    live = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule